// File: doc/BRIEF.md
# Cut-Through Transmit Byte Buffer

This block sits between a bus-side DMA engine that writes frame bytes and a MAC transmitter that reads them out at wire rate. It holds 2048 bytes. It does not start a frame on the wire the moment the first byte arrives. It waits until enough bytes of the frame at the head are stored. That limit is a programmable start level, so a late bus access does not starve the transmitter halfway through a frame. A whole-frame mode goes further and holds each frame until its last byte is stored.

If the transmitter asks for a byte while a frame is on the wire and the buffer is empty, the block reports an underrun. It then abandons that frame. The writer may still be pushing the rest of that frame, and those bytes are taken in and thrown away, so the next frame starts cleanly. Raising the start level trades latency for safety against bus stalls. Setting it at or above the largest frame size gives the same result as whole-frame mode.

Top module: `txct_fifo`

## Requirements
- R1: After reset, tx_go_o, tx_valid_o and underrun_o are 0 and wr_ready_o is 1.
- R2: When whole_frame_i is 0 and the head frame's last byte is not yet stored, tx_go_o rises one cycle after the stored byte count reaches start_lvl_i, and not before. A start_lvl_i of 0 is treated as 1.
- R3: A frame whose last byte (wr_eof_i=1) is stored starts one cycle later even when its length is below start_lvl_i.
- R4: When whole_frame_i is 1, tx_go_o stays 0 until the head frame's last byte is stored, whatever the byte count.
- R5: While tx_go_o is 1, bytes come out on tx_data_o in write order, one per cycle with tx_req_i=1 and tx_valid_o=1. tx_last_o marks the byte written with wr_eof_i. tx_valid_o is never 1 while tx_go_o is 0. After the last byte is taken, tx_go_o is 0 for at least one cycle.
- R6: The buffer holds 2048 bytes. wr_ready_o is 0 while 2048 bytes are stored, and a write offered then is dropped and never appears on tx_data_o.
- R7: tx_req_i=1 while tx_go_o=1 and tx_valid_o=0 is an underrun. In the next cycle underrun_o is 1 for exactly one cycle and tx_go_o is 0.
- R8: After an underrun, written bytes are accepted and discarded up to and including the next byte with wr_eof_i=1, or until a byte with wr_sof_i=1, which is stored. The next frame is sent intact.
- R9: With start_lvl_i of 1536 and whole_frame_i=0, a 1500-byte frame does not start until its last byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write byte offered |
| wr_data_i | input | 8 | Write byte |
| wr_sof_i | input | 1 | Byte is the first of a frame |
| wr_eof_i | input | 1 | Byte is the last of a frame |
| wr_ready_o | output | 1 | Buffer can take a byte |
| start_lvl_i | input | 12 | Per-frame start level in bytes |
| whole_frame_i | input | 1 | Hold each frame until fully stored |
| tx_req_i | input | 1 | Transmitter takes a byte this cycle |
| tx_go_o | output | 1 | Frame released to the wire |
| tx_valid_o | output | 1 | Byte available on tx_data_o |
| tx_data_o | output | 8 | Head byte |
| tx_last_o | output | 1 | Head byte ends the frame |
| underrun_o | output | 1 | One-cycle pulse on an aborted frame |

## Verification
The hardest states to reach are the full buffer and the underrun followed by the discard window. The stimulus fills all 2048 places with a start level far above capacity. It offers one extra byte, lowers the level, and drains everything. It keeps requesting until the buffer runs dry mid-frame. The bench then writes the rest of the abandoned frame, checks that none of it starts or appears, and sends a fresh frame. Random frames with random levels and modes are checked against a bench model of the cycle in which each frame starts.

// File: rtl/txct_pkg.sv
package txct_pkg;
  typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;

  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } txct_entry_t;
endpackage

// File: rtl/txct_store.sv
module txct_store
  import txct_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        we_i,
  input  logic [AW-1:0] waddr_i,
  input  txct_entry_t wdata_i,
  input  logic [AW-1:0] raddr_i,
  output txct_entry_t rdata_o
);
  txct_entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/txct_wr_ctrl.sv
module txct_wr_ctrl #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic          wr_sof_i,
  input  logic          wr_eof_i,
  input  logic          full_i,
  input  logic          abort_i,
  output logic          push_o,
  output logic [AW-1:0] wptr_o,
  output logic          wr_ready_o
);
  logic drop_q, drop_d, drop_eff, hs;
  logic [AW-1:0] wptr_q;

  assign hs       = wr_valid_i && !full_i;
  // a start-of-frame byte always ends the discard window
  assign drop_eff = (drop_q || abort_i) && !wr_sof_i;
  assign push_o   = hs && !drop_eff;

  always_comb begin
    drop_d = drop_q;
    if (abort_i) drop_d = 1'b1;
    if (hs && (wr_sof_i || (drop_eff && wr_eof_i))) drop_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drop_q <= 1'b0;
      wptr_q <= '0;
    end else begin
      drop_q <= drop_d;
      if (push_o) wptr_q <= wptr_q + AW'(1);
    end
  end

  assign wptr_o     = wptr_q;
  assign wr_ready_o = !full_i;
endmodule

// File: rtl/txct_rd_ctrl.sv
module txct_rd_ctrl
  import txct_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] occ_i,
  input  logic          frame_ready_i,
  input  logic          head_last_i,
  input  logic [CW-1:0] start_lvl_i,
  input  logic          whole_frame_i,
  input  logic          tx_req_i,
  output logic          pop_o,
  output logic          abort_o,
  output logic [AW-1:0] rptr_o,
  output logic          tx_go_o,
  output logic          tx_valid_o,
  output logic          underrun_o
);
  tx_state_e state_q, state_d;
  logic [AW-1:0] rptr_q;
  logic [CW-1:0] lvl_eff;
  logic start_ok, empty, sending, underrun_q;

  assign empty    = (occ_i == '0);
  assign lvl_eff  = (start_lvl_i == '0) ? CW'(1) : start_lvl_i;
  // with no complete frame stored, every stored byte belongs to the head frame
  assign start_ok = frame_ready_i || (!whole_frame_i && (occ_i >= lvl_eff));
  assign sending  = (state_q == TX_SEND);
  assign pop_o    = sending && tx_req_i && !empty;
  assign abort_o  = sending && tx_req_i && empty;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TX_IDLE: if (start_ok) state_d = TX_SEND;
      TX_SEND: if (abort_o || (pop_o && head_last_i)) state_d = TX_IDLE;
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= TX_IDLE;
      rptr_q     <= '0;
      underrun_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      underrun_q <= abort_o;
      if (pop_o) rptr_q <= rptr_q + AW'(1);
    end
  end

  assign rptr_o     = rptr_q;
  assign tx_go_o    = sending;
  assign tx_valid_o = sending && !empty;
  assign underrun_o = underrun_q;
endmodule

// File: rtl/txct_fifo.sv
module txct_fifo
  import txct_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_data_i,
  input  logic          wr_sof_i,
  input  logic          wr_eof_i,
  output logic          wr_ready_o,
  input  logic [CW-1:0] start_lvl_i,
  input  logic          whole_frame_i,
  input  logic          tx_req_i,
  output logic          tx_go_o,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  output logic          underrun_o
);
  logic [CW-1:0] occ_q, frames_q;
  logic [AW-1:0] wptr, rptr;
  logic push, pop, abort, full;
  txct_entry_t wentry, rentry;

  assign full = (occ_q == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q    <= '0;
      frames_q <= '0;
    end else begin
      occ_q    <= occ_q + CW'(push) - CW'(pop);
      frames_q <= frames_q + CW'(push && wr_eof_i) - CW'(pop && rentry.last);
    end
  end

  txct_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_sof_i   (wr_sof_i),
    .wr_eof_i   (wr_eof_i),
    .full_i     (full),
    .abort_i    (abort),
    .push_o     (push),
    .wptr_o     (wptr),
    .wr_ready_o (wr_ready_o)
  );

  assign wentry.last = wr_eof_i;
  assign wentry.data = wr_data_i;

  txct_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (wptr),
    .wdata_i (wentry),
    .raddr_i (rptr),
    .rdata_o (rentry)
  );

  txct_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .occ_i         (occ_q),
    .frame_ready_i (frames_q != '0),
    .head_last_i   (rentry.last),
    .start_lvl_i   (start_lvl_i),
    .whole_frame_i (whole_frame_i),
    .tx_req_i      (tx_req_i),
    .pop_o         (pop),
    .abort_o       (abort),
    .rptr_o        (rptr),
    .tx_go_o       (tx_go_o),
    .tx_valid_o    (tx_valid_o),
    .underrun_o    (underrun_o)
  );

  assign tx_data_o = rentry.data;
  assign tx_last_o = tx_valid_o && rentry.last;
endmodule

// File: rtl/txct_fifo_chk.sv
module txct_fifo_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_req_i,
  input logic tx_go_o,
  input logic tx_valid_o,
  input logic tx_last_o,
  input logic underrun_o
);
  assert_underrun_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o);

  assert_underrun_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (!tx_go_o && $past(tx_go_o)));

  assert_valid_in_go_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_go_o);

  assert_last_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_last_o && tx_req_i) |=> !tx_go_o);
endmodule

bind txct_fifo txct_fifo_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_req_i   (tx_req_i),
  .tx_go_o    (tx_go_o),
  .tx_valid_o (tx_valid_o),
  .tx_last_o  (tx_last_o),
  .underrun_o (underrun_o)
);

// File: tb/txct_fifo_tb_top.sv
module txct_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2048;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid_i = 1'b0, wr_sof_i = 1'b0, wr_eof_i = 1'b0, wr_ready_o;
  logic [7:0] wr_data_i = '0;
  logic [CW-1:0] start_lvl_i = '0;
  logic whole_frame_i = 1'b0, tx_req_i = 1'b0;
  logic tx_go_o, tx_valid_o, tx_last_o, underrun_o;
  logic [7:0] tx_data_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  byte unsigned exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  txct_fifo #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit starts(int k, bit eof, int thr, bit whole);
    int lvl = (thr == 0) ? 1 : thr;
    return eof || (!whole && k >= lvl);
  endfunction

  task automatic wr(byte unsigned d, bit sof, bit eof, bit keep);
    wr_valid_i = 1'b1; wr_data_i = d; wr_sof_i = sof; wr_eof_i = eof;
    if (keep && wr_ready_o) exp_q.push_back(d);
    @(negedge clk_i);
    wr_valid_i = 1'b0; wr_sof_i = 1'b0; wr_eof_i = 1'b0;
  endtask

  // pops n bytes; last byte of a frame is expected when ends=1
  task automatic drain(int n, bit ends, bit keep_req, string req);
    int guard = 0;
    while (!tx_go_o && guard < 100) begin @(negedge clk_i); guard++; end
    for (int i = 0; i < n; i++) begin
      byte unsigned e = exp_q.pop_front();
      chk({req, " valid"}, tx_valid_o, 1);
      chk({req, " data"}, tx_data_o, e);
      chk({req, " last"}, tx_last_o, (ends && i == n-1) ? 1 : 0);
      tx_req_i = 1'b1;
      @(negedge clk_i);
    end
    if (!keep_req) tx_req_i = 1'b0;
  endtask

  initial begin
    int i;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R1 go", tx_go_o, 0); chk("R1 valid", tx_valid_o, 0);
    chk("R1 underrun", underrun_o, 0); chk("R1 ready", wr_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: start level 8
    start_lvl_i = CW'(8); whole_frame_i = 1'b0;
    for (i = 0; i < 8; i++) begin
      wr(8'(16 + i), i == 0, 1'b0, 1'b1);
      chk("R2 early", tx_go_o, 0);
    end
    @(negedge clk_i);
    chk("R2 start", tx_go_o, 1);
    for (i = 8; i < 20; i++) wr(8'(16 + i), 1'b0, i == 19, 1'b1);
    drain(20, 1'b1, 1'b0, "R5");
    chk("R5 gap", tx_go_o, 0);

    // R3: short frame under a high level
    start_lvl_i = CW'(100);
    for (i = 0; i < 5; i++) begin
      wr(8'(64 + i), i == 0, i == 4, 1'b1);
      chk("R3 early", tx_go_o, 0);
    end
    @(negedge clk_i);
    chk("R3 start", tx_go_o, 1);
    drain(5, 1'b1, 1'b0, "R3");

    // R4: whole-frame mode with level 1
    start_lvl_i = CW'(1); whole_frame_i = 1'b1;
    for (i = 0; i < 30; i++) wr(8'(100 + i), i == 0, 1'b0, 1'b1);
    @(negedge clk_i);
    chk("R4 held", tx_go_o, 0);
    wr(8'd200, 1'b0, 1'b1, 1'b1);
    chk("R4 eof edge", tx_go_o, 0);
    @(negedge clk_i);
    chk("R4 start", tx_go_o, 1);
    drain(31, 1'b1, 1'b0, "R4");
    whole_frame_i = 1'b0;

    // R9: level 1536, frame of 1500
    start_lvl_i = CW'(1536);
    for (i = 0; i < 1499; i++) wr(8'(i * 3), i == 0, 1'b0, 1'b1);
    @(negedge clk_i);
    chk("R9 held", tx_go_o, 0);
    wr(8'd7, 1'b0, 1'b1, 1'b1);
    @(negedge clk_i);
    chk("R9 start", tx_go_o, 1);
    drain(1500, 1'b1, 1'b0, "R9");

    // R6: fill to capacity, offered extra byte is dropped
    start_lvl_i = CW'(4000);
    for (i = 0; i < DEPTH; i++) wr(8'(i), i == 0, 1'b0, 1'b1);
    chk("R6 full ready", wr_ready_o, 0);
    chk("R6 held", tx_go_o, 0);
    wr(8'hAA, 1'b0, 1'b0, 1'b1);
    start_lvl_i = CW'(1);
    drain(DEPTH, 1'b0, 1'b1, "R6");
    chk("R6 ready again", wr_ready_o, 1);
    chk("R6 extra absent", tx_valid_o, 0);
    chk("R7 still go", tx_go_o, 1);
    @(negedge clk_i);
    chk("R7 pulse", underrun_o, 1);
    chk("R7 go low", tx_go_o, 0);
    tx_req_i = 1'b0;
    @(negedge clk_i);
    chk("R7 single", underrun_o, 0);

    // R8: rest of aborted frame discarded
    for (i = 0; i < 4; i++) begin
      wr(8'(224 + i), 1'b0, i == 3, 1'b0);
      @(negedge clk_i);
      chk("R8 discard", tx_go_o, 0);
    end
    for (i = 0; i < 4; i++) wr(8'(80 + i), i == 0, i == 3, 1'b1);
    drain(4, 1'b1, 1'b0, "R8");

    // random frames, levels and modes
    for (int f = 0; f < 8; f++) begin
      int len = 1 + int'($urandom % 60);
      int thr = int'($urandom % 80);
      bit whole = bit'($urandom % 2);
      bit exp_go = 1'b0;
      start_lvl_i = CW'(thr); whole_frame_i = whole;
      for (int k = 1; k <= len; k++) begin
        exp_go = exp_go || starts(k - 1, 1'b0, thr, whole);
        wr(8'($urandom), k == 1, k == len, 1'b1);
        chk(whole ? "R4 rnd" : "R2 rnd", tx_go_o, int'(exp_go));
      end
      @(negedge clk_i);
      chk("R3 rnd start", tx_go_o, 1);
      drain(len, 1'b1, 1'b0, "R5 rnd");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule